// File: doc/BRIEF.md
# Nine-Bit Serial Transceiver with Transmit Holding Buffer

This block is an asynchronous serial transceiver for 8-bit and 9-bit character frames. Software reaches it through a byte-wide register port: one write to the data address queues a byte for sending, a control register selects the frame length and the buffering policy, and a status register gathers the event flags. In 9-bit frames the extra transmitted bit comes straight from a control bit, so software can place a parity bit or an address marker there.

The transmitter can run with a single holding slot that only accepts a byte while the line is idle. It can also run double-buffered, where the next byte may be written while the current one is still leaving the shifter. The receiver oversamples the line sixteen times per bit. It reports frames whose stop bit is low and all-zero break frames. In multi-drop setups it can filter traffic by address: frames that carry the ninth bit set are compared with a programmable address under a mask, and data frames are only taken in after a match. A free-running tick at sixteen times the bit rate, supplied from outside, paces both directions.

Top module: `sio9_core`

## Requirements
- R1: After reset `txd` is 1, `rx_irq` and `tx_irq` are 0, the status register (address 2) reads 0, the control register (address 1) reads 0 and the mask register (address 4) reads 8'hFF.
- R2: A transmitted frame is a low start bit, the data byte least significant bit first, and a high stop bit, each bit lasting 16 `baud_tick` pulses.
- R3: When control bit 0 (nine-bit mode) is 1, a ninth bit equal to control bit 2 is sent between the last data bit and the stop bit, and the receiver expects a ninth bit in the same place.
- R4: With control bit 1 (double buffering) at 0, a write to the data register (address 0) while a byte is waiting or being sent is ignored. The transmit flag (status bit 1) is set at the end of the stop bit.
- R5: With control bit 1 at 1, one byte written during a transmission is held and sent next, and a further write while that byte is held is ignored. The transmit flag is set each time a held byte moves into the shifter.
- R6: The receiver starts a frame only on a high-to-low transition of the sampled line. Each bit is the majority of the 7th, 8th and 9th of its 16 samples, and a start bit that votes high abandons the frame, so a low pulse shorter than half a bit produces no flag.
- R7: A frame with a high stop bit that passes the address filter sets the receive flag (status bit 0), loads the received byte (read at address 0) and places the ninth bit in status bit 4 (0 in 8-bit mode).
- R8: A frame whose stop bit votes low sets the framing-error flag (status bit 2) and leaves the receive flag and the received byte unchanged.
- R9: A frame in which every data bit, the ninth bit (if present) and the stop bit vote low sets the break flag (status bit 3) as well as the framing-error flag.
- R10: With control bits 0 and 3 both 1, a frame whose ninth bit is 1 is accepted, and opens the filter, only when (byte XOR address register 3) AND mask register 4 is zero; otherwise it closes the filter. A frame whose ninth bit is 0 is accepted only while the filter is open.
- R11: Writing status with a 1 in bits 0 to 3 clears the matching flag. `tx_irq` equals the transmit flag and `rx_irq` is the OR of the receive, framing-error and break flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| rx_irq | output | 1 | Receive event request (receive, framing or break flag) |
| tx_irq | output | 1 | Transmit flag |

## Verification
A wrong holding-slot state shows on `txd` within one frame time: either an extra frame goes out or an expected one is missing, and the scoreboard compares every frame bit by bit. A sample counter or vote that is off by a position makes the decoded byte, ninth bit or stop bit wrong on the very frame concerned, and this appears in the status and data registers about half a bit after the stop bit. A stale address-filter state only becomes visible on the next data frame, which is taken in or dropped against the bench's own model of the filter. Each of these mistakes is therefore caught within two frames.

// File: rtl/sio9_pkg.sv
package sio9_pkg;
  typedef struct packed {
    logic addr_auto;
    logic tx_b9;
    logic dbuf;
    logic nine;
  } ctrl_t;

  localparam logic [2:0] A_DATA = 3'd0;
  localparam logic [2:0] A_CTRL = 3'd1;
  localparam logic [2:0] A_STAT = 3'd2;
  localparam logic [2:0] A_MADR = 3'd3;
  localparam logic [2:0] A_MMSK = 3'd4;

  function automatic logic majority3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/sio9_tx.sv
module sio9_tx #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_byte,
  input  logic          nine,
  input  logic          dbuf,
  input  logic          b9,
  output logic          txd,
  output logic          load_evt,
  output logic          done_evt
);
  localparam int FW  = DW + 3;
  localparam int CW  = $clog2(OVS);
  localparam int BIW = $clog2(FW);

  logic [DW-1:0]  hold_q;
  logic           hold_v;
  logic [FW-1:0]  sh_q;
  logic           busy_q;
  logic [CW-1:0]  tc_q;
  logic [BIW-1:0] bidx_q, last_q;
  logic           accept, bit_end;

  function automatic logic [FW-1:0] pack_frame(input logic [DW-1:0] d, input logic n9,
                                               input logic x9);
    return {1'b1, (n9 ? x9 : 1'b1), d, 1'b0};
  endfunction

  assign accept   = wr_stb && !hold_v && (dbuf || !busy_q);
  assign load_evt = hold_v && !busy_q;
  assign bit_end  = busy_q && tick && (tc_q == CW'(OVS - 1));
  assign done_evt = bit_end && (bidx_q == last_q);
  assign txd      = busy_q ? sh_q[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      hold_v <= 1'b0;
      sh_q   <= '1;
      busy_q <= 1'b0;
      tc_q   <= '0;
      bidx_q <= '0;
      last_q <= '0;
    end else begin
      if (load_evt) begin
        hold_v <= 1'b0;
        sh_q   <= pack_frame(hold_q, nine, b9);
        busy_q <= 1'b1;
        tc_q   <= '0;
        bidx_q <= '0;
        last_q <= nine ? BIW'(DW + 2) : BIW'(DW + 1);
      end else if (busy_q && tick) begin
        if (bit_end) begin
          tc_q <= '0;
          if (bidx_q == last_q) begin
            busy_q <= 1'b0;
          end else begin
            bidx_q <= bidx_q + 1'b1;
            sh_q   <= {1'b1, sh_q[FW-1:1]};
          end
        end else begin
          tc_q <= tc_q + 1'b1;
        end
      end
      if (accept) begin
        hold_v <= 1'b1;
        hold_q <= wr_byte;
      end
    end
  end

  // R5: a full holding slot keeps its byte when written again
  p_full_hold_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_v && wr_stb && !load_evt |=> hold_v && $stable(hold_q));
  // R4: single-buffer write during a transmission leaves the slot empty
  p_busy_write_dropped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !dbuf && wr_stb && !hold_v |=> !hold_v);
  // R2: the last bit time of every frame is the high stop bit
  p_stop_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |-> txd);
  // R2: the first bit time after a load is the low start bit
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> !txd);
endmodule

// File: rtl/sio9_rx.sv
module sio9_rx #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rxd,
  input  logic          nine,
  output logic          frame_evt,
  output logic [DW-1:0] frm_data,
  output logic          frm_b9,
  output logic          frm_stop,
  output logic          frm_zero
);
  import sio9_pkg::*;
  localparam int CW  = $clog2(OVS);
  localparam int MID = OVS / 2;
  localparam int BIW = $clog2(DW + 3);

  logic           s1_q, s2_q, prev_q, act_q, v0_q, v1_q;
  logic [CW-1:0]  sc_q;
  logic [BIW-1:0] bidx_q, last_idx;
  logic [DW:0]    bits_q;
  logic           vote_now, vbit;

  assign last_idx  = nine ? BIW'(DW + 2) : BIW'(DW + 1);
  assign vote_now  = act_q && tick && (sc_q == CW'(MID + 1));
  assign vbit      = majority3(v0_q, v1_q, s2_q);
  assign frame_evt = vote_now && (bidx_q == last_idx);
  assign frm_data  = bits_q[DW-1:0];
  assign frm_b9    = nine & bits_q[DW];
  assign frm_stop  = vbit;
  assign frm_zero  = ~|bits_q[DW-1:0] && !frm_b9;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
      act_q  <= 1'b0;
      v0_q   <= 1'b1;
      v1_q   <= 1'b1;
      sc_q   <= '0;
      bidx_q <= '0;
      bits_q <= '0;
    end else begin
      s1_q <= rxd;
      s2_q <= s1_q;
      if (tick) prev_q <= s2_q;
      if (!act_q) begin
        if (tick && prev_q && !s2_q) begin
          act_q  <= 1'b1;
          sc_q   <= CW'(1);
          bidx_q <= '0;
        end
      end else if (tick) begin
        if (sc_q == CW'(MID - 1)) v0_q <= s2_q;
        if (sc_q == CW'(MID))     v1_q <= s2_q;
        if (sc_q == CW'(OVS - 1)) begin
          sc_q   <= '0;
          bidx_q <= bidx_q + 1'b1;
        end else begin
          sc_q <= sc_q + 1'b1;
        end
        if (vote_now) begin
          if (bidx_q == '0) begin
            if (vbit) act_q <= 1'b0;
          end else if (bidx_q == last_idx) begin
            act_q <= 1'b0;
          end else begin
            bits_q[bidx_q - 1'b1] <= vbit;
          end
        end
      end
    end
  end

  // R6: a frame ends at the stop-bit vote and the receiver returns to hunting
  p_idle_after_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_evt |=> !act_q);
  // R6: a start bit voted high abandons the frame before any data is taken
  p_false_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vote_now && (bidx_q == '0) && v0_q && v1_q |=> !act_q);
endmodule

// File: rtl/sio9_core.sv
module sio9_core #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [2:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          rxd,
  output logic          txd,
  output logic          rx_irq,
  output logic          tx_irq
);
  import sio9_pkg::*;

  ctrl_t         ctrl_q;
  logic [DW-1:0] addr_q, mask_q, rx_data_q;
  logic          rx_b9_q, rx_f, tx_f, fe_f, brk_f, hit_q;
  logic          tx_load, tx_done, tx_set;
  logic          frm_evt, frm_b9, frm_stop, frm_zero;
  logic [DW-1:0] frm_data;
  logic          auto_on, good_evt, accept, ferr_evt, brk_evt;
  logic [3:0]    clr;

  function automatic logic addr_ok(input logic [DW-1:0] b, input logic [DW-1:0] a,
                                   input logic [DW-1:0] m);
    return ((b ^ a) & m) == '0;
  endfunction

  sio9_tx #(.DW(DW), .OVS(OVS)) tx_i (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick),
    .wr_stb(wr_en && (wr_addr == A_DATA)), .wr_byte(wr_data),
    .nine(ctrl_q.nine), .dbuf(ctrl_q.dbuf), .b9(ctrl_q.tx_b9),
    .txd(txd), .load_evt(tx_load), .done_evt(tx_done));

  sio9_rx #(.DW(DW), .OVS(OVS)) rx_i (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rxd(rxd), .nine(ctrl_q.nine),
    .frame_evt(frm_evt), .frm_data(frm_data), .frm_b9(frm_b9),
    .frm_stop(frm_stop), .frm_zero(frm_zero));

  assign auto_on  = ctrl_q.addr_auto && ctrl_q.nine;
  assign good_evt = frm_evt && frm_stop;
  assign accept   = good_evt && (!auto_on ||
                    (frm_b9 ? addr_ok(frm_data, addr_q, mask_q) : hit_q));
  assign ferr_evt = frm_evt && !frm_stop;
  assign brk_evt  = ferr_evt && frm_zero;
  assign tx_set   = ctrl_q.dbuf ? tx_load : tx_done;
  assign clr      = (wr_en && (wr_addr == A_STAT)) ? wr_data[3:0] : 4'b0;
  assign rx_irq   = rx_f | fe_f | brk_f;
  assign tx_irq   = tx_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      addr_q    <= '0;
      mask_q    <= '1;
      rx_data_q <= '0;
      rx_b9_q   <= 1'b0;
      rx_f      <= 1'b0;
      tx_f      <= 1'b0;
      fe_f      <= 1'b0;
      brk_f     <= 1'b0;
      hit_q     <= 1'b0;
    end else begin
      if (wr_en && (wr_addr == A_CTRL)) ctrl_q <= ctrl_t'(wr_data[3:0]);
      if (wr_en && (wr_addr == A_MADR)) addr_q <= wr_data;
      if (wr_en && (wr_addr == A_MMSK)) mask_q <= wr_data;
      if (good_evt && auto_on && frm_b9) hit_q <= addr_ok(frm_data, addr_q, mask_q);
      if (accept) begin
        rx_data_q <= frm_data;
        rx_b9_q   <= frm_b9;
      end
      rx_f  <= (rx_f  & ~clr[0]) | accept;
      tx_f  <= (tx_f  & ~clr[1]) | tx_set;
      fe_f  <= (fe_f  & ~clr[2]) | ferr_evt;
      brk_f <= (brk_f & ~clr[3]) | brk_evt;
    end
  end

  always_comb begin
    case (rd_addr)
      A_DATA:  rd_data = rx_data_q;
      A_CTRL:  rd_data = DW'(ctrl_q);
      A_STAT:  rd_data = DW'({rx_b9_q, brk_f, fe_f, tx_f, rx_f});
      A_MADR:  rd_data = addr_q;
      A_MMSK:  rd_data = mask_q;
      default: rd_data = '0;
    endcase
  end

  // R7: the receive flag only rises after a frame with a good stop bit
  p_rx_flag_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_f) |-> $past(frm_evt && frm_stop));
  // R9: a break is always reported together with a framing error
  p_break_with_ferr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_f) |-> fe_f);
  // R10: data frames are dropped while the address filter is closed
  p_closed_filter_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frm_evt && auto_on && !frm_b9 && !hit_q |=> $stable(rx_data_q));
  // R8: a framing error never loads the received byte
  p_ferr_no_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frm_evt && !frm_stop |=> $stable(rx_data_q));
  // R5: in double-buffer mode a load raises the transmit flag next cycle
  p_tx_flag_dbuf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load && ctrl_q.dbuf |=> tx_f);
  // R4: in single-buffer mode a load does not raise the transmit flag
  p_tx_flag_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load && !ctrl_q.dbuf && !tx_f |=> !tx_f);
endmodule

// File: tb/sio9_core_tb_top.sv
module sio9_core_tb_top;
  localparam time BT = 256ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       rxd = 1'b1;
  logic       txd, rx_irq, tx_irq;

  int checks = 0;
  int errors = 0;
  int mon_frames = 0;
  bit cfg_nine = 0, m_auto = 0, m_hit = 0;
  logic [7:0] m_addr = 8'h00, m_mask = 8'hFF, last_rx = 8'h00;
  logic [8:0] tx_q[$];
  logic [8:0] rx_q[$];

  sio9_core dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .rxd(rxd), .txd(txd),
    .rx_irq(rx_irq), .tx_irq(tx_irq));

  always #2ns clk = ~clk;

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    #1ns;
    d = rd_data;
  endtask

  task automatic set_ctrl(input logic [7:0] v);
    cfg_nine = v[0];
    m_auto   = v[3];
    reg_wr(3'd1, v);
  endtask

  // Scoreboard monitor: decodes txd at mid-bit and pops the expected frame
  initial begin
    logic [7:0] d;
    logic       st, sp, b9;
    logic [8:0] e;
    forever begin
      @(negedge txd);
      #(BT / 2);
      st = txd;
      for (int i = 0; i < 8; i++) begin
        #(BT);
        d[i] = txd;
      end
      b9 = 1'b0;
      if (cfg_nine) begin
        #(BT);
        b9 = txd;
      end
      #(BT);
      sp = txd;
      mon_frames++;
      if (tx_q.size() == 0) begin
        check(1'b0, "R2 unexpected frame", {23'd0, b9, d}, 32'h0);
      end else begin
        e = tx_q.pop_front();
        check(st == 1'b0, "R2 start bit", {31'd0, st}, 32'd0);
        check(sp == 1'b1, "R2 stop bit", {31'd0, sp}, 32'd1);
        check({b9, d} == e, "R2/R3 frame content", {23'd0, b9, d}, {23'd0, e});
      end
    end
  end

  task automatic rx_frame(input string req, input logic [7:0] d, input bit b9, input bit stopv);
    bit acc;
    logic [7:0] st, dt;
    logic [8:0] e;
    acc = stopv;
    if (stopv && m_auto && cfg_nine) begin
      if (b9) m_hit = (((d ^ m_addr) & m_mask) == 8'h00);
      acc = m_hit;
    end
    if (acc) rx_q.push_back({b9 & cfg_nine, d});
    rxd = 1'b0;
    #(BT);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      #(BT);
    end
    if (cfg_nine) begin
      rxd = b9;
      #(BT);
    end
    rxd = stopv;
    #(BT);
    rxd = 1'b1;
    #(2 * BT);
    reg_rd(3'd2, st);
    reg_rd(3'd0, dt);
    check(st[0] == acc, {req, " receive flag"}, {31'd0, st[0]}, {31'd0, acc});
    check(rx_irq == (acc | !stopv), "R11 rx_irq", {31'd0, rx_irq}, {31'd0, acc | !stopv});
    if (acc) begin
      e = rx_q.pop_front();
      check({st[4], dt} == e, {req, " received data"}, {23'd0, st[4], dt}, {23'd0, e});
      last_rx = dt;
    end else begin
      check(dt == last_rx, {req, " data kept"}, {24'd0, dt}, {24'd0, last_rx});
    end
    check(st[2] == !stopv, "R8 framing error", {31'd0, st[2]}, {31'd0, !stopv});
    check(st[3] == (!stopv && d == 8'h00 && !(cfg_nine && b9)), "R9 break",
          {31'd0, st[3]}, {31'd0, !stopv && d == 8'h00 && !(cfg_nine && b9)});
    reg_wr(3'd2, 8'h0D);
  endtask

  initial begin
    #400us;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int base;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check(txd == 1'b1, "R1 txd idle", {31'd0, txd}, 32'd1);
    check(!rx_irq && !tx_irq, "R1 irqs", {30'd0, rx_irq, tx_irq}, 32'd0);
    reg_rd(3'd2, v); check(v == 8'h00, "R1 status", {24'd0, v}, 32'h0);
    reg_rd(3'd1, v); check(v == 8'h00, "R1 control", {24'd0, v}, 32'h0);
    reg_rd(3'd4, v); check(v == 8'hFF, "R1 mask", {24'd0, v}, 32'hFF);

    // R4: single buffer, 8-bit frames, second write ignored
    base = mon_frames;
    tx_q.push_back({1'b0, 8'hA5});
    reg_wr(3'd0, 8'hA5);
    repeat (4) @(negedge clk);
    reg_wr(3'd0, 8'h3C);
    reg_rd(3'd2, v); check(v[1] == 1'b0, "R4 no flag at load", {31'd0, v[1]}, 32'd0);
    @(posedge tx_irq);
    check(mon_frames == base + 1, "R4 flag after stop", mon_frames, base + 1);
    #(12 * BT);
    check(mon_frames == base + 1, "R4 busy write dropped", mon_frames, base + 1);
    reg_wr(3'd2, 8'h02);
    check(!tx_irq, "R11 tx flag cleared", {31'd0, tx_irq}, 32'd0);

    // R3: nine-bit frames with the ninth bit from the control register
    set_ctrl(8'h05);
    tx_q.push_back({1'b1, 8'h5A});
    reg_wr(3'd0, 8'h5A);
    @(posedge tx_irq);
    reg_wr(3'd2, 8'h02);
    set_ctrl(8'h01);
    tx_q.push_back({1'b0, 8'h81});
    reg_wr(3'd0, 8'h81);
    @(posedge tx_irq);
    reg_wr(3'd2, 8'h02);
    #(2 * BT);
    check(tx_q.size() == 0, "R3 nine-bit frames sent", tx_q.size(), 0);

    // R5: double buffering
    set_ctrl(8'h02);
    base = mon_frames;
    tx_q.push_back({1'b0, 8'h11});
    tx_q.push_back({1'b0, 8'h22});
    reg_wr(3'd0, 8'h11);
    repeat (3) @(negedge clk);
    reg_rd(3'd2, v); check(v[1] == 1'b1, "R5 flag on load", {31'd0, v[1]}, 32'd1);
    reg_wr(3'd2, 8'h02);
    reg_wr(3'd0, 8'h22);
    reg_wr(3'd0, 8'h33);
    reg_rd(3'd2, v); check(v[1] == 1'b0, "R5 flag waits", {31'd0, v[1]}, 32'd0);
    @(posedge tx_irq);
    check(mon_frames == base + 1, "R5 flag when held byte moves", mon_frames, base + 1);
    reg_wr(3'd2, 8'h02);
    #(14 * BT);
    check(mon_frames == base + 2, "R5 third write dropped", mon_frames, base + 2);
    reg_wr(3'd2, 8'h02);

    // R6: short glitch does not start a frame
    set_ctrl(8'h00);
    rxd = 1'b0; #24ns; rxd = 1'b1;
    #(2 * BT);
    reg_rd(3'd2, v); check(v == 8'h00, "R6 glitch rejected", {24'd0, v}, 32'h0);

    // R7, R8, R9: receive paths in 8-bit mode
    rx_frame("R7", 8'hA5, 1'b0, 1'b1);
    rx_frame("R6", 8'h00, 1'b0, 1'b1);
    rx_frame("R8", 8'h3C, 1'b0, 1'b0);
    rx_frame("R9", 8'h00, 1'b0, 1'b0);
    set_ctrl(8'h01);
    rx_frame("R7", 8'hC3, 1'b1, 1'b1);
    rx_frame("R9", 8'h00, 1'b1, 1'b0);

    // R10: address filter
    reg_wr(3'd3, 8'h12); m_addr = 8'h12;
    reg_wr(3'd4, 8'hFF); m_mask = 8'hFF;
    set_ctrl(8'h09);
    rx_frame("R10", 8'h55, 1'b0, 1'b1);
    rx_frame("R10", 8'h34, 1'b1, 1'b1);
    rx_frame("R10", 8'h12, 1'b1, 1'b1);
    rx_frame("R10", 8'h77, 1'b0, 1'b1);
    rx_frame("R10", 8'h35, 1'b1, 1'b1);
    rx_frame("R10", 8'h88, 1'b0, 1'b1);
    reg_wr(3'd3, 8'h10); m_addr = 8'h10;
    reg_wr(3'd4, 8'hF0); m_mask = 8'hF0;
    rx_frame("R10", 8'h1F, 1'b1, 1'b1);
    rx_frame("R10", 8'h66, 1'b0, 1'b1);
    rx_frame("R10", 8'h2F, 1'b1, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule